// File: doc/BRIEF.md
# Mixed-Latency Issue Hazard Checker

This block sits beside the decode stage of an in-order integer pipeline whose instruction classes finish at different depths. An ALU operation writes its destination two cycles after leaving decode. A load passes through two memory stages and writes four cycles after decode. A store writes nothing, but it reads its data register late, in the second half of its second memory stage, three cycles after decode. All other source registers are read during decode. There is no operand forwarding.

Every cycle the checker looks at the instruction in decode: its class, its two source register numbers and its destination register number. It compares them against a record of pending register writes and pending late store reads, and decides whether the instruction may issue. A dependence on an older write that has not yet landed (read after write) causes a stall. So does a write that would overtake an older pending write to the same register (write after write), a write that would land before an older store has read the old value (write after read), and a write that would share a write-back cycle with an older instruction (port collision). When the checker stalls, decode holds the instruction and a bubble with no reservation moves on, while in-flight work keeps draining. A stall is reported together with a cause vector.

Top module: `mixlat_hazard_unit`

## Requirements
- R1: A synchronous active-high reset clears all pending writes and pending store reads. In the first cycle after reset, no instruction stalls.
- R2: Class encoding is 0 none, 1 ALU, 2 load and 3 store. Some sources are read in decode: both sources of an ALU op, srcA of a load (its base), and srcA of a store (its base). Such a source stalls with cause bit 0 when an older write to the same register lands in a later cycle. A write that lands in the same cycle as the decode read does not stall.
- R3: A store's srcB is its data register and is read three cycles after decode. It stalls on cause bit 0 only when an older write to it lands after that read. With the default latencies, this never happens.
- R4: A writing instruction stalls with cause bit 1 when an older pending write to the same destination would land strictly after its own write. Its own write lands 2 cycles after issue for an ALU op and 4 for a load.
- R5: A writing instruction stalls with cause bit 2 when its write would land in the same cycle as, or before, the late data read of an older store that names the same register.
- R6: A writing instruction stalls with cause bit 3 when any older pending write lands in the same cycle as its own write.
- R7: Register 0 is never a dependence. A source of 0 never raises cause bit 0. An instruction whose destination is 0 writes nothing, raises no cause bits 1 to 3, and reserves no write cycle.
- R8: A stalled instruction records nothing. Only an instruction issued without a stall reserves a write or a store read.
- R9: Two reads of the same register never stall. The none class never stalls, whatever its register fields hold.
- R10: stall is high exactly when at least one bit of stallCause is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| decClass | input | 2 | Class of the instruction in decode: 0 none, 1 ALU, 2 load, 3 store |
| decSrcA | input | 5 | First source register (base for loads and stores) |
| decSrcB | input | 5 | Second source register (store data for stores) |
| decDst | input | 5 | Destination register (ignored for stores) |
| stall | output | 1 | Hold the decode instruction this cycle |
| stallCause | output | 4 | Bit 0 RAW, bit 1 WAW, bit 2 WAR, bit 3 write-port collision |

## Verification
The assertions assume that any instruction presented without a stall was accepted by the pipeline. The write-after-write property relies on this, because it reads an unstalled load in the previous cycle as an issued one. They also assume reset is applied before the first instruction, so that history-based properties never consult cycles before reset. The bench honours both: its model records an instruction as issued exactly when the expected stall is low, and it asserts reset at start and again in mid-run. The random stimulus draws register numbers from a narrow range that includes 0, so that dependences, collisions and register-0 cases occur often.

// File: rtl/mlh_pkg.sv
package mlh_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ALU   = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } instClass_e;

  // strobes from the issue control to the reservation tracker
  typedef struct packed {
    logic insAlu;    // reserve an ALU-latency write
    logic insLoad;   // reserve a load-latency write
    logic insStore;  // record a late store data read
  } resvStrobe_t;

  localparam int CAUSE_RAW  = 0;
  localparam int CAUSE_WAW  = 1;
  localparam int CAUSE_WAR  = 2;
  localparam int CAUSE_PORT = 3;
  localparam int CAUSE_W    = 4;

endpackage

// File: rtl/mlh_resv_track.sv
module mlh_resv_track
  import mlh_pkg::*;
#(
  parameter  int REG_BITS     = 5,
  parameter  int ALU_LAT      = 2,
  parameter  int LOAD_LAT     = 4,
  parameter  int STORE_RD_LAT = 3,
  localparam int WR_DEPTH     = LOAD_LAT - 1,
  localparam int RD_DEPTH     = STORE_RD_LAT - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  resvStrobe_t         strobe,
  input  logic [REG_BITS-1:0] srcA,
  input  logic [REG_BITS-1:0] srcB,
  input  logic [REG_BITS-1:0] newDst,
  output logic [WR_DEPTH-1:0] wrBusy,
  output logic [WR_DEPTH-1:0] wrHitA,
  output logic [WR_DEPTH-1:0] wrHitB,
  output logic [WR_DEPTH-1:0] wrHitD,
  output logic [RD_DEPTH-1:0] rdHitD
);

  // slot i holds a write landing i+1 cycles from now
  localparam int ALU_SLOT  = ALU_LAT - 2;
  localparam int LOAD_SLOT = LOAD_LAT - 2;
  // slot j holds a store data read happening j+1 cycles from now
  localparam int RD_SLOT   = STORE_RD_LAT - 2;

  logic [WR_DEPTH-1:0] wrVld, wrVldSh, wrVldNxt;
  logic [REG_BITS-1:0] wrReg    [WR_DEPTH];
  logic [REG_BITS-1:0] wrRegSh  [WR_DEPTH];
  logic [REG_BITS-1:0] wrRegNxt [WR_DEPTH];

  logic [RD_DEPTH-1:0] rdVld, rdVldSh, rdVldNxt;
  logic [REG_BITS-1:0] rdReg    [RD_DEPTH];
  logic [REG_BITS-1:0] rdRegSh  [RD_DEPTH];
  logic [REG_BITS-1:0] rdRegNxt [RD_DEPTH];

  logic srcANz, srcBNz, dstNz;
  assign srcANz = (srcA != '0);
  assign srcBNz = (srcB != '0);
  assign dstNz  = (newDst != '0);

  // time advances every cycle: each record moves one slot closer
  for (genvar i = 0; i < WR_DEPTH; i++) begin : g_wrShift
    if (i < WR_DEPTH - 1) begin : g_mid
      assign wrVldSh[i] = wrVld[i+1];
      assign wrRegSh[i] = wrReg[i+1];
    end else begin : g_top
      assign wrVldSh[i] = 1'b0;
      assign wrRegSh[i] = '0;
    end
  end

  for (genvar j = 0; j < RD_DEPTH; j++) begin : g_rdShift
    if (j < RD_DEPTH - 1) begin : g_mid
      assign rdVldSh[j] = rdVld[j+1];
      assign rdRegSh[j] = rdReg[j+1];
    end else begin : g_top
      assign rdVldSh[j] = 1'b0;
      assign rdRegSh[j] = '0;
    end
  end

  always_comb begin
    wrVldNxt = wrVldSh;
    for (int i = 0; i < WR_DEPTH; i++) wrRegNxt[i] = wrRegSh[i];
    if (strobe.insAlu) begin
      wrVldNxt[ALU_SLOT] = 1'b1;
      wrRegNxt[ALU_SLOT] = newDst;
    end
    if (strobe.insLoad) begin
      wrVldNxt[LOAD_SLOT] = 1'b1;
      wrRegNxt[LOAD_SLOT] = newDst;
    end
  end

  always_comb begin
    rdVldNxt = rdVldSh;
    for (int j = 0; j < RD_DEPTH; j++) rdRegNxt[j] = rdRegSh[j];
    if (strobe.insStore) begin
      rdVldNxt[RD_SLOT] = 1'b1;
      rdRegNxt[RD_SLOT] = srcB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrVld <= '0;
      rdVld <= '0;
      for (int i = 0; i < WR_DEPTH; i++) wrReg[i] <= '0;
      for (int j = 0; j < RD_DEPTH; j++) rdReg[j] <= '0;
    end else begin
      wrVld <= wrVldNxt;
      rdVld <= rdVldNxt;
      for (int i = 0; i < WR_DEPTH; i++) wrReg[i] <= wrRegNxt[i];
      for (int j = 0; j < RD_DEPTH; j++) rdReg[j] <= rdRegNxt[j];
    end
  end

  // parallel comparators against every pending record
  for (genvar i = 0; i < WR_DEPTH; i++) begin : g_wrCmp
    assign wrBusy[i] = wrVld[i];
    assign wrHitA[i] = wrVld[i] && srcANz && (wrReg[i] == srcA);
    assign wrHitB[i] = wrVld[i] && srcBNz && (wrReg[i] == srcB);
    assign wrHitD[i] = wrVld[i] && dstNz  && (wrReg[i] == newDst);
  end

  for (genvar j = 0; j < RD_DEPTH; j++) begin : g_rdCmp
    assign rdHitD[j] = rdVld[j] && dstNz && (rdReg[j] == newDst);
  end

endmodule

// File: rtl/mlh_issue_ctrl.sv
module mlh_issue_ctrl
  import mlh_pkg::*;
#(
  parameter  int ALU_LAT      = 2,
  parameter  int LOAD_LAT     = 4,
  parameter  int STORE_RD_LAT = 3,
  localparam int WR_DEPTH     = LOAD_LAT - 1,
  localparam int RD_DEPTH     = STORE_RD_LAT - 1
) (
  input  instClass_e          decClass,
  input  logic                dstNonZero,
  input  logic [WR_DEPTH-1:0] wrBusy,
  input  logic [WR_DEPTH-1:0] wrHitA,
  input  logic [WR_DEPTH-1:0] wrHitB,
  input  logic [WR_DEPTH-1:0] wrHitD,
  input  logic [RD_DEPTH-1:0] rdHitD,
  output logic                stall,
  output logic [CAUSE_W-1:0]  stallCause,
  output resvStrobe_t         strobe
);

  logic isWriter;
  int   wrLat;
  logic rawEarly, rawLate, wawAny, warAny, portAny;

  always_comb begin
    isWriter = ((decClass == CLS_ALU) || (decClass == CLS_LOAD)) && dstNonZero;
    wrLat    = (decClass == CLS_ALU) ? ALU_LAT : LOAD_LAT;

    // sources read in decode
    rawEarly = ((decClass != CLS_NONE) && (|wrHitA)) ||
               ((decClass == CLS_ALU)  && (|wrHitB));

    rawLate = 1'b0;
    wawAny  = 1'b0;
    portAny = 1'b0;
    for (int i = 0; i < WR_DEPTH; i++) begin
      // store data is read STORE_RD_LAT cycles out; only later writes matter
      if ((decClass == CLS_STORE) && wrHitB[i] && (i + 1 > STORE_RD_LAT))
        rawLate = 1'b1;
      if (isWriter && wrHitD[i] && (i + 1 > wrLat))
        wawAny = 1'b1;
      if (isWriter && wrBusy[i] && (i + 1 == wrLat))
        portAny = 1'b1;
    end

    warAny = 1'b0;
    for (int j = 0; j < RD_DEPTH; j++) begin
      // write lands before or in the same cycle as the store read
      if (isWriter && rdHitD[j] && (j + 1 >= wrLat))
        warAny = 1'b1;
    end

    stallCause             = '0;
    stallCause[CAUSE_RAW]  = rawEarly || rawLate;
    stallCause[CAUSE_WAW]  = wawAny;
    stallCause[CAUSE_WAR]  = warAny;
    stallCause[CAUSE_PORT] = portAny;
    stall                  = |stallCause;

    strobe.insAlu   = !stall && (decClass == CLS_ALU)  && dstNonZero;
    strobe.insLoad  = !stall && (decClass == CLS_LOAD) && dstNonZero;
    strobe.insStore = !stall && (decClass == CLS_STORE);
  end

endmodule

// File: rtl/mixlat_hazard_unit.sv
module mixlat_hazard_unit
  import mlh_pkg::*;
#(
  parameter int REG_BITS     = 5,
  parameter int ALU_LAT      = 2,
  parameter int LOAD_LAT     = 4,
  parameter int STORE_RD_LAT = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          decClass,
  input  logic [REG_BITS-1:0] decSrcA,
  input  logic [REG_BITS-1:0] decSrcB,
  input  logic [REG_BITS-1:0] decDst,
  output logic                stall,
  output logic [CAUSE_W-1:0]  stallCause
);

  localparam int WR_DEPTH = LOAD_LAT - 1;
  localparam int RD_DEPTH = STORE_RD_LAT - 1;

  resvStrobe_t         strobe;
  logic [WR_DEPTH-1:0] wrBusy, wrHitA, wrHitB, wrHitD;
  logic [RD_DEPTH-1:0] rdHitD;

  mlh_resv_track #(
    .REG_BITS    (REG_BITS),
    .ALU_LAT     (ALU_LAT),
    .LOAD_LAT    (LOAD_LAT),
    .STORE_RD_LAT(STORE_RD_LAT)
  ) uTrack (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .srcA  (decSrcA),
    .srcB  (decSrcB),
    .newDst(decDst),
    .wrBusy(wrBusy),
    .wrHitA(wrHitA),
    .wrHitB(wrHitB),
    .wrHitD(wrHitD),
    .rdHitD(rdHitD)
  );

  mlh_issue_ctrl #(
    .ALU_LAT     (ALU_LAT),
    .LOAD_LAT    (LOAD_LAT),
    .STORE_RD_LAT(STORE_RD_LAT)
  ) uCtrl (
    .decClass  (instClass_e'(decClass)),
    .dstNonZero(decDst != '0),
    .wrBusy    (wrBusy),
    .wrHitA    (wrHitA),
    .wrHitB    (wrHitB),
    .wrHitD    (wrHitD),
    .rdHitD    (rdHitD),
    .stall     (stall),
    .stallCause(stallCause),
    .strobe    (strobe)
  );

endmodule

// File: rtl/mixlat_hazard_sva.sv
module mixlat_hazard_sva #(
  parameter int REG_BITS = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          decClass,
  input logic [REG_BITS-1:0] decSrcA,
  input logic [REG_BITS-1:0] decDst,
  input logic                stall,
  input logic [3:0]          stallCause
);

  // R1
  post_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !stall);

  // R9
  nop_never_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    (decClass == 2'd0) |-> !stall);

  // R4
  load_then_alu_waw_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(decClass) == 2'd2 && !$past(stall) &&
     $past(decDst) != '0 && decClass == 2'd1 && decDst == $past(decDst))
    |-> stallCause[1]);

  // R6
  store_no_write_causes_chk: assert property (@(posedge clk) disable iff (rst)
    (decClass == 2'd3) |-> (stallCause[3:1] == 3'b000));

  // R6
  load_never_collides_chk: assert property (@(posedge clk) disable iff (rst)
    (decClass == 2'd2) |-> !stallCause[3]);

  // R7
  zero_dst_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (decDst == '0) |-> (stallCause[3:1] == 3'b000));

  // R3
  store_data_late_chk: assert property (@(posedge clk) disable iff (rst)
    (decClass == 2'd3 && decSrcA == '0) |-> !stallCause[0]);

  // R10
  stall_matches_cause_chk: assert property (@(posedge clk) disable iff (rst)
    stall == (stallCause != 4'b0000));

endmodule

bind mixlat_hazard_unit mixlat_hazard_sva #(.REG_BITS(REG_BITS)) uSva (
  .clk       (clk),
  .rst       (rst),
  .decClass  (decClass),
  .decSrcA   (decSrcA),
  .decDst    (decDst),
  .stall     (stall),
  .stallCause(stallCause)
);

// File: tb/tb_mixlat_hazard_unit.sv
module tb_mixlat_hazard_unit;

  localparam int CLK_PERIOD = 10;
  localparam int HIST = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] decClass = 2'd0;
  logic [4:0] decSrcA = '0, decSrcB = '0, decDst = '0;
  logic       stall;
  logic [3:0] stallCause;

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;

  // issued-instruction history with absolute issue cycles
  int         hCyc [HIST];
  logic [1:0] hCls [HIST];
  logic [4:0] hB   [HIST];
  logic [4:0] hD   [HIST];
  int         hPtr = 0;

  mixlat_hazard_unit dut (
    .clk       (clk),
    .rst       (rst),
    .decClass  (decClass),
    .decSrcA   (decSrcA),
    .decSrcB   (decSrcB),
    .decDst    (decDst),
    .stall     (stall),
    .stallCause(stallCause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic clearHist();
    for (int h = 0; h < HIST; h++) begin
      hCyc[h] = -100; hCls[h] = 2'd0; hB[h] = '0; hD[h] = '0;
    end
  endtask

  // expected causes from the timing rules: ALU writes issue+2,
  // load writes issue+4, store data read at issue+3
  function automatic logic [3:0] modelCause(input logic [1:0] c,
      input logic [4:0] a, input logic [4:0] b, input logic [4:0] d, input int now);
    logic [3:0] r;
    bit wr;
    int nw;
    r  = '0;
    wr = ((c == 2'd1) || (c == 2'd2)) && (d != 0);
    nw = now + ((c == 2'd1) ? 2 : 4);
    for (int h = 0; h < HIST; h++) begin
      bit hw;
      int wc;
      hw = ((hCls[h] == 2'd1) || (hCls[h] == 2'd2)) && (hD[h] != 0);
      wc = hCyc[h] + ((hCls[h] == 2'd1) ? 2 : 4);
      if (hw) begin
        if (c != 0 && a != 0 && a == hD[h] && wc > now) r[0] = 1'b1;
        if (c == 2'd1 && b != 0 && b == hD[h] && wc > now) r[0] = 1'b1;
        if (c == 2'd3 && b != 0 && b == hD[h] && wc > now + 3) r[0] = 1'b1;
        if (wr && wc == nw) r[3] = 1'b1;
        if (wr && wc > nw && d == hD[h]) r[1] = 1'b1;
      end
      if (hCls[h] == 2'd3 && hB[h] != 0 && wr && hB[h] == d && nw <= hCyc[h] + 3)
        r[2] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [3:0] act,
                     input logic [3:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  // one decode cycle; hand = -1 means model check only
  task automatic step(input logic [1:0] c, input logic [4:0] a, input logic [4:0] b,
                      input logic [4:0] d, input int hand, input string tag);
    logic [3:0] exp;
    @(negedge clk);
    decClass = c; decSrcA = a; decSrcB = b; decDst = d;
    #1;
    exp = modelCause(c, a, b, d, cyc);
    chk(stallCause == exp, tag, stallCause, exp);
    chk(stall == (exp != 0), {tag, " R10 stall"}, {3'b0, stall}, {3'b0, exp != 0});
    if (hand >= 0)
      chk(stallCause == hand[3:0], {tag, " directed"}, stallCause, hand[3:0]);
    if (exp == 0 && c != 0) begin
      hCyc[hPtr] = cyc; hCls[hPtr] = c; hB[hPtr] = b; hD[hPtr] = d;
      hPtr = (hPtr + 1) % HIST;
    end
  endtask

  task automatic nops(input int n);
    for (int k = 0; k < n; k++) step(2'd0, 5'd0, 5'd0, 5'd0, 0, "R9 nop");
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; decClass = 2'd0;
    repeat (2) @(posedge clk);
    clearHist();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    clearHist();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state, then R2 RAW stall and R8 hold
    step(2'd1, 5'd1, 5'd2, 5'd3, 0, "R1 first after reset");
    step(2'd1, 5'd3, 5'd0, 5'd4, 1, "R2 RAW on ALU source");
    step(2'd1, 5'd3, 5'd0, 5'd4, 0, "R2 write same cycle as read");
    // R4 WAW, then R6 port collision, then issue
    step(2'd2, 5'd0, 5'd0, 5'd1, 0, "R4 load issue");
    step(2'd1, 5'd0, 5'd0, 5'd1, 2, "R4 WAW ALU after load");
    step(2'd1, 5'd0, 5'd0, 5'd1, 8, "R6 port collision");
    step(2'd1, 5'd0, 5'd0, 5'd1, 0, "R4 resolved");
    // R5 WAR against late store read
    step(2'd3, 5'd0, 5'd5, 5'd0, 0, "R5 store issue");
    step(2'd1, 5'd0, 5'd0, 5'd5, 4, "R5 WAR");
    step(2'd1, 5'd0, 5'd0, 5'd5, 0, "R5 resolved");
    // R3 late store data after load, base RAW still applies
    step(2'd2, 5'd0, 5'd0, 5'd6, 0, "R3 load issue");
    step(2'd3, 5'd0, 5'd6, 5'd0, 0, "R3 store data read late");
    step(2'd3, 5'd6, 5'd0, 5'd0, 1, "R2 store base RAW");
    nops(5);
    // R7 register 0 reserves nothing
    step(2'd2, 5'd0, 5'd0, 5'd0, 0, "R7 load to r0");
    step(2'd0, 5'd0, 5'd0, 5'd0, 0, "R7 gap");
    step(2'd1, 5'd0, 5'd0, 5'd9, 0, "R7 no slot held by r0 load");
    step(2'd1, 5'd0, 5'd0, 5'd0, 0, "R7 ALU to r0");
    nops(4);
    // R9 RAR and nop with matching fields
    step(2'd1, 5'd8, 5'd8, 5'd10, 0, "R9 RAR first");
    step(2'd1, 5'd8, 5'd8, 5'd11, 0, "R9 RAR second");
    step(2'd0, 5'd11, 5'd10, 5'd11, 0, "R9 nop ignores fields");
    nops(4);
    // R8 stalled load leaves no reservation
    step(2'd1, 5'd0, 5'd0, 5'd12, 0, "R8 producer");
    step(2'd2, 5'd12, 5'd0, 5'd13, 1, "R8 stalled load");
    step(2'd0, 5'd0, 5'd0, 5'd0, 0, "R8 withdraw");
    step(2'd1, 5'd13, 5'd0, 5'd0, 0, "R8 no reservation from stall");
    // R1 mid-run reset clears pending load
    step(2'd2, 5'd0, 5'd0, 5'd14, 0, "R1 load before reset");
    doReset();
    step(2'd1, 5'd14, 5'd14, 5'd14, 0, "R1 cleared by reset");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] c;
      logic [4:0] a, b, d;
      c = 2'($urandom_range(0, 3));
      a = 5'($urandom_range(0, 5));
      b = 5'($urandom_range(0, 5));
      d = 5'($urandom_range(0, 5));
      step(c, a, b, d, -1, "R2 R4 R5 R6 random");
    end

    finishRun();
  end

endmodule